// File: doc/BRIEF.md
# Built-in Test Screen Generator

This block sits between a video decoder and its output format converter and can replace the decoded picture with a full-screen test image. Three images are available: a solid blue field, a solid black field and eight vertical colour bars at 75% amplitude. A fourth setting passes the decoded pixels through unchanged. The image is chosen by a two-bit field taken from bits 2:1 of an 8-bit format control byte. Output is 4:2:2 YCbCr with one luma byte and one chroma byte per pixel, so the converter downstream can apply whatever output format is selected.

Pixel timing comes from the incoming video whenever a source is reported present. Without a source, timing comes from an internal free-running line and frame counter. That counter uses a fixed active width and one of two line counts, picked by a standard-select input. A change between the two timing bases only happens at a frame start, so no output frame is ever split between two timings.

Top module: `test_screen_gen`

## Requirements
- R1: While `rst_n` is low, and on the first output after release, `out_de` and `out_sof` are 0, `out_y` is 16 and `out_c` is 128.
- R2: Every output is registered once: the outputs seen after a clock edge are computed from the inputs and state present at that edge.
- R3: Whenever `out_de` is 0, `out_y` is 16 and `out_c` is 128, in every mode.
- R4: Mode is `fmt_ctrl[2:1]`: 00 pass-through, 01 blue, 10 black, 11 colour bars; the other bits of `fmt_ctrl` have no effect. Blue active pixels carry Y=41, Cb=240, Cr=110. Black active pixels carry Y=16, Cb=128, Cr=128.
- R5: In pass-through mode with source timing selected, an active pixel copies `src_y` and `src_c`. With internal timing selected, an active pixel is black (Y=16, C=128).
- R6: Colour bars: pixel index x counts active pixels since the start of the current active run (the first is 0). Bar = x / (ACT_PIX/8), held at 7 beyond the last bar. The bars in order 0..7 are white (180,128,128), yellow (162,44,142), cyan (131,156,44), green (112,72,58), magenta (84,184,198), red (65,100,212), blue (35,212,114) and black (16,128,128), each given as (Y,Cb,Cr). For every generated image, `out_c` carries Cb on even x and Cr on odd x.
- R7: Internal timing: the pixel counter h runs 0..H_TOTAL-1. The line counter v advances at the end of each line and wraps to 0 once it reaches the line count less one. The line count is LINES_625 when `std_625` is 1 and LINES_525 otherwise, and the active line count follows the same choice. A pixel is active when h < ACT_PIX and v is below the active line count. A frame starts at h=0, v=0, and both counters are 0 after reset.
- R8: With internal timing in use, source timing takes over in the cycle where `src_present` and `src_sof` are both 1. With source timing in use, internal timing takes over in the cycle where `src_present` is 0 and the internal frame starts. There is no other switch, so every change in the timing base coincides with `out_sof` = 1.
- R9: While source timing is in use, `out_de` and `out_sof` follow `src_de` and `src_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_ctrl | input | 8 | Format control byte; bits 2:1 select the image |
| std_625 | input | 1 | 1 selects the 625-line internal timing, 0 the 525-line timing |
| src_present | input | 1 | Decoder reports that input video is detected |
| src_de | input | 1 | Active-pixel qualifier of the decoded stream |
| src_sof | input | 1 | First active pixel of a decoded frame |
| src_y | input | 8 | Decoded luma |
| src_c | input | 8 | Decoded chroma, Cb/Cr interleaved |
| out_de | output | 1 | Active-pixel qualifier of the output |
| out_sof | output | 1 | Frame start of the output |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma, Cb on even pixels, Cr on odd |

## Verification
Every result is due exactly one clock after the inputs and state that produce it. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs with a model that advanced its own internal counter, timing selection and pixel index over that same rising edge. The timing base switch is likewise due on the first output of the new frame: the bench predicts the cycle from its own copy of the source and internal frame starts, and requires `out_sof` there. Mode changes count only from the edge after the new `fmt_ctrl` is applied, so no check samples a value still in flight.

// File: rtl/tsg_pkg.sv
// Package: shared mode encoding, pixel type and fixed colour values for
// the test screen generator. Assumes 8-bit BT.601-range YCbCr.
package tsg_pkg;

    typedef enum logic [1:0] {
        SCR_PASS  = 2'b00,
        SCR_BLUE  = 2'b01,
        SCR_BLACK = 2'b10,
        SCR_BARS  = 2'b11
    } scr_mode_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ycc_t;

    localparam logic [7:0] BLANK_Y = 8'd16;
    localparam logic [7:0] BLANK_C = 8'd128;

    localparam ycc_t BLUE_FIELD  = '{y: 8'd41, cb: 8'd240, cr: 8'd110};
    localparam ycc_t BLACK_FIELD = '{y: 8'd16, cb: 8'd128, cr: 8'd128};

    // Colour of one of the eight 75% bars, index 0 at the left edge.
    function automatic ycc_t bar_colour(input logic [2:0] idx);
        ycc_t c;
        case (idx)
            3'd0:    c = '{y: 8'd180, cb: 8'd128, cr: 8'd128};
            3'd1:    c = '{y: 8'd162, cb: 8'd44,  cr: 8'd142};
            3'd2:    c = '{y: 8'd131, cb: 8'd156, cr: 8'd44};
            3'd3:    c = '{y: 8'd112, cb: 8'd72,  cr: 8'd58};
            3'd4:    c = '{y: 8'd84,  cb: 8'd184, cr: 8'd198};
            3'd5:    c = '{y: 8'd65,  cb: 8'd100, cr: 8'd212};
            3'd6:    c = '{y: 8'd35,  cb: 8'd212, cr: 8'd114};
            default: c = '{y: 8'd16,  cb: 8'd128, cr: 8'd128};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tsg_int_timing.sv
// Module: free-running internal line/frame timing.
// Produces an active-pixel flag and a frame-start flag from a pixel counter
// and a line counter. The line count is picked by std_b at every line end,
// so a standard change mid-frame takes effect on the next line wrap check.
// Assumes H_TOTAL > ACT_PIX and line counts of at least 2.
module tsg_int_timing #(
    parameter int ACT_PIX   = 720,
    parameter int H_TOTAL   = 858,
    parameter int ACT_L_A   = 480,
    parameter int LINES_A   = 525,
    parameter int ACT_L_B   = 576,
    parameter int LINES_B   = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic std_b,
    output logic int_de,
    output logic int_sof
);
    localparam int MAX_LINES = (LINES_B > LINES_A) ? LINES_B : LINES_A;
    localparam int HW        = $clog2(H_TOTAL);
    localparam int VW        = $clog2(MAX_LINES);

    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;
    logic [VW-1:0] last_line;
    logic [VW-1:0] act_lines;

    // Pick line-count limits for the selected standard.
    always_comb begin
        if (std_b) begin
            last_line = VW'(LINES_B - 1);
            act_lines = VW'(ACT_L_B);
        end else begin
            last_line = VW'(LINES_A - 1);
            act_lines = VW'(ACT_L_A);
        end
    end

    // Advance pixel and line counters; wrap at line and frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (h_q == HW'(H_TOTAL - 1)) begin
            h_q <= '0;
            if (v_q >= last_line) begin
                v_q <= '0;
            end else begin
                v_q <= v_q + 1'b1;
            end
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    // Decode active region and frame start from the counters.
    always_comb begin
        int_de  = (h_q < HW'(ACT_PIX)) && (v_q < act_lines);
        int_sof = (h_q == '0) && (v_q == '0);
    end

endmodule

// File: rtl/tsg_timing_sel.sv
// Module: chooses between source timing and internal timing.
// The selection only changes on a frame start of the timing being switched
// to (source frame start when a source appears, internal frame start when
// it is lost). The chosen timing is valid in the same cycle as the switch.
module tsg_timing_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic src_present,
    input  logic src_de,
    input  logic src_sof,
    input  logic int_de,
    input  logic int_sof,
    output logic sel_src,
    output logic sel_de,
    output logic sel_sof
);
    logic use_src_q;

    // Decide this cycle's timing base from the held choice and frame starts.
    always_comb begin
        if (use_src_q) begin
            sel_src = !(!src_present && int_sof);
        end else begin
            sel_src = src_present && src_sof;
        end
        sel_de  = sel_src ? src_de  : int_de;
        sel_sof = sel_src ? src_sof : int_sof;
    end

    // Hold the timing base chosen this cycle for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_src_q <= 1'b0;
        end else begin
            use_src_q <= sel_src;
        end
    end

endmodule

// File: rtl/tsg_pattern.sv
// Module: per-pixel image generation.
// Counts the pixel index within the current active run and produces the
// Y and interleaved C value for the selected mode. Output is combinational;
// the top registers it. Assumes ACT_PIX is at least 8.
module tsg_pattern
    import tsg_pkg::*;
#(
    parameter int ACT_PIX = 720
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       de,
    input  logic       use_src,
    input  scr_mode_t  mode,
    input  logic [7:0] src_y,
    input  logic [7:0] src_c,
    output logic [7:0] pix_y,
    output logic [7:0] pix_c
);
    localparam int BAR_W  = ACT_PIX / 8;
    localparam int XW     = $clog2(ACT_PIX) + 1;
    localparam int BAR_SH = $clog2(BAR_W);

    logic          run_q;
    logic [XW-1:0] cnt_q;
    logic [XW-1:0] x;
    logic [XW-1:0] bar_q;
    logic [2:0]    bar_idx;
    ycc_t          field;

    assign x = run_q ? cnt_q : '0;

    // Bar number: shift when the bar width is a power of two, else divide.
    generate
        if ((BAR_W & (BAR_W - 1)) == 0) begin : g_bar_shift
            assign bar_q = x >> BAR_SH;
        end else begin : g_bar_div
            assign bar_q = x / XW'(BAR_W);
        end
    endgenerate

    // Clamp the bar number to the last bar.
    always_comb begin
        bar_idx = (bar_q > XW'(7)) ? 3'd7 : bar_q[2:0];
    end

    // Track the pixel index within the active run, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (de) begin
            run_q <= 1'b1;
            cnt_q <= (x == '1) ? x : x + 1'b1;
        end else begin
            run_q <= 1'b0;
        end
    end

    // Choose the full-field colour for the generated modes.
    always_comb begin
        case (mode)
            SCR_BLUE:  field = BLUE_FIELD;
            SCR_BARS:  field = bar_colour(bar_idx);
            default:   field = BLACK_FIELD;
        endcase
    end

    // Form the output pixel: blanking, pass-through or generated colour.
    always_comb begin
        if (!de) begin
            pix_y = BLANK_Y;
            pix_c = BLANK_C;
        end else if (mode == SCR_PASS && use_src) begin
            pix_y = src_y;
            pix_c = src_c;
        end else begin
            pix_y = field.y;
            pix_c = x[0] ? field.cr : field.cb;
        end
    end

endmodule

// File: rtl/test_screen_gen.sv
// Module: top of the built-in test screen generator.
// Selects source or internal timing, builds the pixel for the mode held in
// fmt_ctrl[2:1] and registers all outputs once. Assumes the source stream
// is synchronous to clk with one pixel per cycle.
module test_screen_gen
    import tsg_pkg::*;
#(
    parameter int ACT_PIX   = 720,
    parameter int H_TOTAL   = 858,
    parameter int ACT_L_525 = 480,
    parameter int LINES_525 = 525,
    parameter int ACT_L_625 = 576,
    parameter int LINES_625 = 625
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fmt_ctrl,
    input  logic       std_625,
    input  logic       src_present,
    input  logic       src_de,
    input  logic       src_sof,
    input  logic [7:0] src_y,
    input  logic [7:0] src_c,
    output logic       out_de,
    output logic       out_sof,
    output logic [7:0] out_y,
    output logic [7:0] out_c
);
    logic      int_de;
    logic      int_sof;
    logic      sel_src;
    logic      sel_de;
    logic      sel_sof;
    logic [7:0] pix_y;
    logic [7:0] pix_c;
    logic      out_src_q;
    scr_mode_t mode;

    assign mode = scr_mode_t'(fmt_ctrl[2:1]);

    tsg_int_timing #(
        .ACT_PIX (ACT_PIX),
        .H_TOTAL (H_TOTAL),
        .ACT_L_A (ACT_L_525),
        .LINES_A (LINES_525),
        .ACT_L_B (ACT_L_625),
        .LINES_B (LINES_625)
    ) u_int_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .std_b   (std_625),
        .int_de  (int_de),
        .int_sof (int_sof)
    );

    tsg_timing_sel u_timing_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_present (src_present),
        .src_de      (src_de),
        .src_sof     (src_sof),
        .int_de      (int_de),
        .int_sof     (int_sof),
        .sel_src     (sel_src),
        .sel_de      (sel_de),
        .sel_sof     (sel_sof)
    );

    tsg_pattern #(
        .ACT_PIX (ACT_PIX)
    ) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .de      (sel_de),
        .use_src (sel_src),
        .mode    (mode),
        .src_y   (src_y),
        .src_c   (src_c),
        .pix_y   (pix_y),
        .pix_c   (pix_c)
    );

    // Register the output pixel, its timing flags and the timing base used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_de    <= 1'b0;
            out_sof   <= 1'b0;
            out_y     <= BLANK_Y;
            out_c     <= BLANK_C;
            out_src_q <= 1'b0;
        end else begin
            out_de    <= sel_de;
            out_sof   <= sel_sof;
            out_y     <= pix_y;
            out_c     <= pix_c;
            out_src_q <= sel_src;
        end
    end

endmodule

// File: rtl/test_screen_gen_chk.sv
// Module: assertion checker for test_screen_gen, attached by bind.
// Observes ports plus the registered timing-base flag of the output stage.
module test_screen_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] fmt_ctrl,
    input logic       src_de,
    input logic [7:0] src_y,
    input logic [7:0] src_c,
    input logic       out_de,
    input logic       out_sof,
    input logic [7:0] out_y,
    input logic [7:0] out_c,
    input logic       used_src
);

    p_blank_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_y == 8'd16 && out_c == 8'd128));

    p_black_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt_ctrl[2:1]) == 2'b10) |-> (out_y == 8'd16 && out_c == 8'd128));

    p_blue_luma_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt_ctrl[2:1]) == 2'b01 && out_de) |-> (out_y == 8'd41));

    p_pass_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt_ctrl[2:1]) == 2'b00 && out_de && used_src)
            |-> (out_y == $past(src_y) && out_c == $past(src_c)));

    p_bar_luma_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt_ctrl[2:1]) == 2'b11 && out_de)
            |-> (out_y inside {8'd180, 8'd162, 8'd131, 8'd112,
                               8'd84, 8'd65, 8'd35, 8'd16}));

    p_switch_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (used_src != $past(used_src)) |-> out_sof);

    p_src_de_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        used_src |-> (out_de == $past(src_de)));

endmodule

bind test_screen_gen test_screen_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_ctrl (fmt_ctrl),
    .src_de   (src_de),
    .src_y    (src_y),
    .src_c    (src_c),
    .out_de   (out_de),
    .out_sof  (out_sof),
    .out_y    (out_y),
    .out_c    (out_c),
    .used_src (out_src_q)
);

// File: tb/tb_test_screen_gen.sv
`timescale 1ns/1ps
// Bench: random mode, standard and source-presence phases with a reference
// model of the internal timing, the timing switch and the pixel index.
module tb_test_screen_gen;
    localparam int ACT_PIX = 16;
    localparam int H_TOT   = 20;
    localparam int AL_525  = 4;
    localparam int LN_525  = 6;
    localparam int AL_625  = 5;
    localparam int LN_625  = 8;
    localparam int S_HTOT  = 22;
    localparam int S_LINES = 5;
    localparam int S_ACTL  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fmt_ctrl = 8'h00;
    logic       std_625 = 1'b0;
    logic       src_present = 1'b0;
    logic       src_de = 1'b0;
    logic       src_sof = 1'b0;
    logic [7:0] src_y = 8'h00;
    logic [7:0] src_c = 8'h00;
    logic       out_de;
    logic       out_sof;
    logic [7:0] out_y;
    logic [7:0] out_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int  ih = 0, iv = 0, sh = 0, sv = 0, cnt = 0;
    bit  use_src = 1'b0, run = 1'b0;

    always #2.5 clk = ~clk;

    test_screen_gen #(
        .ACT_PIX(ACT_PIX), .H_TOTAL(H_TOT),
        .ACT_L_525(AL_525), .LINES_525(LN_525),
        .ACT_L_625(AL_625), .LINES_625(LN_625)
    ) dut (
        .clk(clk), .rst_n(rst_n), .fmt_ctrl(fmt_ctrl), .std_625(std_625),
        .src_present(src_present), .src_de(src_de), .src_sof(src_sof),
        .src_y(src_y), .src_c(src_c),
        .out_de(out_de), .out_sof(out_sof), .out_y(out_y), .out_c(out_c)
    );

    function automatic logic [23:0] bar_ref(input int b);
        case (b)
            0: return {8'd180, 8'd128, 8'd128};
            1: return {8'd162, 8'd44,  8'd142};
            2: return {8'd131, 8'd156, 8'd44};
            3: return {8'd112, 8'd72,  8'd58};
            4: return {8'd84,  8'd184, 8'd198};
            5: return {8'd65,  8'd100, 8'd212};
            6: return {8'd35,  8'd212, 8'd114};
            default: return {8'd16, 8'd128, 8'd128};
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_src();
        src_de  = src_present && (sh < ACT_PIX) && (sv < S_ACTL);
        src_sof = src_present && (sh == 0) && (sv == 0);
        src_y   = 8'($urandom);
        src_c   = 8'($urandom);
    endtask

    // One cycle: predict the output of the last edge, compare, drive anew.
    task automatic step();
        int lines, al, x, b, mode;
        bit int_de, int_sof, sel, de, sof, sw;
        logic [7:0] ey, ec;
        logic [23:0] col;
        @(negedge clk);
        lines   = std_625 ? LN_625 : LN_525;
        al      = std_625 ? AL_625 : AL_525;
        int_de  = (ih < ACT_PIX) && (iv < al);
        int_sof = (ih == 0) && (iv == 0);
        sel     = use_src ? !(!src_present && int_sof) : (src_present && src_sof);
        sw      = (sel != use_src);
        de      = sel ? src_de : int_de;
        sof     = sel ? src_sof : int_sof;
        x       = run ? cnt : 0;
        mode    = int'(fmt_ctrl[2:1]);
        ey = 8'd16; ec = 8'd128;
        if (de) begin
            if (mode == 0) begin
                if (sel) begin ey = src_y; ec = src_c; end
            end else if (mode == 1) begin
                ey = 8'd41; ec = x[0] ? 8'd110 : 8'd240;
            end else if (mode == 3) begin
                b = x / (ACT_PIX / 8);
                if (b > 7) b = 7;
                col = bar_ref(b);
                ey = col[23:16]; ec = x[0] ? col[7:0] : col[15:8];
            end
        end
        // model advance
        if (ih == H_TOT - 1) begin
            ih = 0;
            iv = (iv >= lines - 1) ? 0 : iv + 1;
        end else ih++;
        sh = (sh == S_HTOT - 1) ? 0 : sh + 1;
        if (sh == 0) sv = (sv == S_LINES - 1) ? 0 : sv + 1;
        use_src = sel;
        if (de) begin cnt = x + 1; run = 1'b1; end else run = 1'b0;
        // compare
        if (sw) check("R8 switch at frame start", {14'd0, out_sof, out_de}, {14'd0, 1'b1, de});
        else if (sel) check("R9 source timing", {14'd0, out_sof, out_de}, {14'd0, sof, de});
        else check("R7 internal timing", {14'd0, out_sof, out_de}, {14'd0, sof, de});
        if (!de) check("R3 blanking levels", {out_y, out_c}, {ey, ec});
        else if (mode == 0) check("R5 R2 pass-through", {out_y, out_c}, {ey, ec});
        else if (mode == 3) check("R6 colour bars", {out_y, out_c}, {ey, ec});
        else check("R4 blue/black field", {out_y, out_c}, {ey, ec});
        // next inputs
        drive_src();
    endtask

    task automatic run_phase(input int n, input int fixed_mode);
        for (int i = 0; i < n; i++) begin
            step();
            if (fixed_mode >= 0) begin
                fmt_ctrl = {5'($urandom), 2'(fixed_mode), 1'($urandom)};
            end else if ($urandom_range(0, 39) == 0) begin
                fmt_ctrl = 8'($urandom);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7));
        fmt_ctrl = 8'hF9; // other bits set, mode 00
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {out_y, out_c}, {8'd16, 8'd128});
        check("R1 reset flags", {14'd0, out_sof, out_de}, 16'd0);
        rst_n = 1'b1;
        drive_src();
        // R7 and R6: full frames of bars on internal 525 timing
        run_phase(300, 3);
        run_phase(200, 1);   // R4 blue
        run_phase(200, 2);   // R4 black
        run_phase(200, 0);   // R5 internal pass-through gives black
        std_625 = 1'b1;
        run_phase(400, -1);
        // R8: source appears at a random phase, takes over at its frame start
        sh = int'($urandom_range(0, S_HTOT - 1));
        src_present = 1'b1;
        drive_src();
        run_phase(400, 0);   // R5 and R9 pass-through of source
        run_phase(600, -1);
        src_present = 1'b0;  // R8: hand back at internal frame start
        drive_src();
        run_phase(500, 3);
        std_625 = 1'b0;
        for (int k = 0; k < 8; k++) begin
            src_present = 1'($urandom);
            if ($urandom_range(0, 1) == 1) std_625 = ~std_625;
            drive_src();
            run_phase(int'($urandom_range(150, 500)), -1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule